// File: doc/BRIEF.md
# Smooth-Scroll Character Address Controller

This block manages the addressing of a 14-slot character memory that feeds a 12-position single-line character display. Twelve slots are on screen at any moment. The other two sit just outside the visible window and hold the next characters to scroll in. The block keeps four pieces of state: a write address counter, an entry mode (step direction plus an optional shift-on-write), a whole-character display offset and a sub-character dot shift of 0 to 5 dots. Every whole-character shift sets the dot shift back to zero. The dot shift therefore walks between character steps, and the host gets a smooth horizontal scroll by alternating dot-shift and display-shift commands.

A host-side decoder presents one command per cycle on `cmd_valid`/`cmd_op`/`cmd_arg`, and character bytes on `wr_valid`/`wr_data`. The block forwards each accepted byte to the character memory on the same cycle through `mem_we`/`mem_addr`/`mem_wdata`. The display refresh logic asks for a visible position on `pos_idx` and receives, combinationally, the memory slot to fetch on `pos_entry` together with the current `dot_shift`.

Clearing fills all slots with the blank code, one slot per clock. The controller has two states. S_IDLE accepts commands and writes; the clear command takes it to S_CLEAR. S_CLEAR issues the blank writes, holds `busy`, and returns to S_IDLE after the write to slot 13.

Top module: `scroll_addr_ctrl`

## Requirements
- R1: For request position p (0 to 11), `pos_entry` equals (offset + p) mod 14, combinationally, where offset is the display offset.
- R2: The address counter and the display offset stay in 0..13 and wrap modulo 14 in both directions (13 steps up to 0, 0 steps down to 13).
- R3: An accepted write drives `mem_we`=1, `mem_addr`=address counter and `mem_wdata`=`wr_data` in the same cycle. From the next cycle the counter is one higher when the increment flag is 1, or one lower when it is 0.
- R4: When the shift-on-write flag is set, each accepted write also moves the offset: +1 (left) when the increment flag is 1, -1 (right) when it is 0. The dot shift is left unchanged.
- R5: Display shift (`cmd_op`=3) moves the offset by +1 when `cmd_arg[0]`=0 (left) or by -1 when it is 1 (right). It leaves the address counter unchanged and sets the dot shift to 0.
- R6: Dot shift (`cmd_op`=5) loads `cmd_arg[2:0]` into `dot_shift` for codes 0 to 5; codes 6 and 7 load 0.
- R7: Clear (`cmd_op`=0) sets the address counter to 0 and the increment flag to 1, and keeps the shift-on-write flag and the offset. It then writes 0x20 to slots 0 to 13 in ascending order, one per cycle, with `busy`=1 for exactly those 14 cycles.
- R8: Return home (`cmd_op`=1) sets the address counter and the offset to 0 and writes no memory.
- R9: Address shift (`cmd_op`=4) moves the address counter by +1 when `cmd_arg[0]`=1 or by -1 when it is 0, and writes no memory.
- R10: Set address (`cmd_op`=6) loads `cmd_arg[3:0]` into the address counter; values 14 and 15 load 0 and 1.
- R11: While `busy`=1, commands and write strobes are ignored: the address counter does not change and `mem_wdata` stays 0x20.
- R12: When a command and a write arrive in the same idle cycle, the command executes and the write is dropped (`mem_we`=0).
- R13: Entry mode (`cmd_op`=2) sets the increment flag from `cmd_arg[1]` and the shift-on-write flag from `cmd_arg[0]`. After reset the address is 0, the offset is 0, `dot_shift` is 0, the increment flag is 1, shift-on-write is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (0 clear, 1 home, 2 entry mode, 3 display shift, 4 address shift, 5 dot shift, 6 set address, 7 none) |
| cmd_arg | input | 8 | Command argument |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | 8 | Character code to write |
| pos_idx | input | 4 | Visible position requested by refresh |
| pos_entry | output | 4 | Memory slot for the requested position |
| dot_shift | output | 3 | Current sub-character dot shift |
| addr_cnt | output | 4 | Address counter |
| busy | output | 1 | Clear in progress |
| mem_we | output | 1 | Character memory write enable |
| mem_addr | output | 4 | Character memory write address |
| mem_wdata | output | 8 | Character memory write data |

## Verification
The memory write port reacts in the same cycle as the write strobe, so the bench samples it 1 ns after driving the strobe. Address, offset, flag and dot-shift changes take one register stage and are sampled at the falling edge after the accepting rising edge. The position mapping is combinational and is swept over all twelve positions for every one of the fourteen offsets. The clear sequence runs its first blank write in the cycle after the command edge and its last thirteen cycles later, so the bench checks one slot at each following falling edge. It then confirms `busy` is low at the fifteenth.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
    typedef enum logic [2:0] {
        OP_CLEAR   = 3'd0,
        OP_HOME    = 3'd1,
        OP_ENTRY   = 3'd2,
        OP_DSHIFT  = 3'd3,
        OP_ASHIFT  = 3'd4,
        OP_DOT     = 3'd5,
        OP_SETADDR = 3'd6,
        OP_NONE    = 3'd7
    } op_e;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_CLEAR = 1'b1
    } state_e;
endpackage

// File: rtl/scroll_ring_ctr.sv
module scroll_ring_ctr #(
    parameter int N = 14,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] LAST = W'(N - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (step) begin
            if (up) value <= (value == LAST) ? '0 : value + 1'b1;
            else    value <= (value == '0) ? LAST : value - 1'b1;
        end
    end

    assert_ring_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        value <= LAST);
endmodule

// File: rtl/scroll_pos_map.sv
module scroll_pos_map #(
    parameter int N  = 14,
    parameter int W  = $clog2(N),
    parameter int PW = 4
) (
    input  logic [W-1:0]  offset,
    input  logic [PW-1:0] pos,
    output logic [W-1:0]  entry
);
    logic [W:0] sum;

    always_comb begin
        sum = (W+1)'(offset) + (W+1)'(pos);
        if (sum >= (W+1)'(N)) entry = W'(sum - (W+1)'(N));
        else                  entry = W'(sum);
    end
endmodule

// File: rtl/scroll_addr_ctrl.sv
module scroll_addr_ctrl
    import scroll_pkg::*;
#(
    parameter int         N_ENTRIES = 14,
    parameter int         N_VISIBLE = 12,
    parameter int         DATA_W    = 8,
    parameter int         MAX_DOT   = 5,
    parameter logic [7:0] BLANK     = 8'h20
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [2:0]                    cmd_op,
    input  logic [7:0]                    cmd_arg,
    input  logic                          wr_valid,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(N_VISIBLE)-1:0]  pos_idx,
    output logic [$clog2(N_ENTRIES)-1:0]  pos_entry,
    output logic [$clog2(MAX_DOT+1)-1:0]  dot_shift,
    output logic [$clog2(N_ENTRIES)-1:0]  addr_cnt,
    output logic                          busy,
    output logic                          mem_we,
    output logic [$clog2(N_ENTRIES)-1:0]  mem_addr,
    output logic [DATA_W-1:0]             mem_wdata
);
    localparam int AW   = $clog2(N_ENTRIES);
    localparam int PW   = $clog2(N_VISIBLE);
    localparam int DOTW = $clog2(MAX_DOT + 1);
    localparam logic [AW-1:0]   LAST_SLOT = AW'(N_ENTRIES - 1);
    localparam logic [DOTW-1:0] DOT_LIMIT = DOTW'(MAX_DOT);

    state_e        state, state_nx;
    op_e           op;
    logic [AW-1:0] clr_cnt;
    logic [AW-1:0] offset;
    logic          inc_mode;
    logic          shift_on_wr;
    logic          accept_cmd;
    logic          accept_wr;
    logic          addr_load, addr_step, addr_up;
    logic [AW-1:0] addr_load_val, req_addr;
    logic          off_load, off_step, off_up;
    logic [DOTW-1:0] dot_code;

    assign op         = op_e'(cmd_op);
    assign busy       = (state == S_CLEAR);
    assign accept_cmd = cmd_valid && (state == S_IDLE);
    assign accept_wr  = wr_valid && !cmd_valid && (state == S_IDLE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept_cmd && op == OP_CLEAR) state_nx = S_CLEAR;
            S_CLEAR: if (clr_cnt == LAST_SLOT)         state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            clr_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == S_CLEAR) clr_cnt <= (clr_cnt == LAST_SLOT) ? '0 : clr_cnt + 1'b1;
            else                  clr_cnt <= '0;
        end
    end

    // memory write port outputs
    always_comb begin
        unique case (state)
            S_CLEAR: begin
                mem_we    = 1'b1;
                mem_addr  = clr_cnt;
                mem_wdata = DATA_W'(BLANK);
            end
            default: begin
                mem_we    = accept_wr;
                mem_addr  = addr_cnt;
                mem_wdata = wr_data;
            end
        endcase
    end

    // address counter control
    always_comb begin
        req_addr      = cmd_arg[AW-1:0];
        addr_load_val = (req_addr >= AW'(N_ENTRIES)) ? req_addr - AW'(N_ENTRIES) : req_addr;
        addr_load     = 1'b0;
        addr_step     = 1'b0;
        addr_up       = inc_mode;
        if (accept_cmd) begin
            unique case (op)
                OP_CLEAR, OP_HOME: begin
                    addr_load     = 1'b1;
                    addr_load_val = '0;
                end
                OP_SETADDR: addr_load = 1'b1;
                OP_ASHIFT: begin
                    addr_step = 1'b1;
                    addr_up   = cmd_arg[0];
                end
                default: ;
            endcase
        end else if (accept_wr) begin
            addr_step = 1'b1;
        end
    end

    // display offset control
    always_comb begin
        off_load = accept_cmd && (op == OP_HOME);
        off_step = 1'b0;
        off_up   = inc_mode;
        if (accept_cmd && op == OP_DSHIFT) begin
            off_step = 1'b1;
            off_up   = !cmd_arg[0];
        end else if (accept_wr && shift_on_wr) begin
            off_step = 1'b1;
        end
    end

    scroll_ring_ctr #(.N(N_ENTRIES), .W(AW)) u_addr_ctr (
        .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(addr_load_val),
        .step(addr_step), .up(addr_up), .value(addr_cnt)
    );

    scroll_ring_ctr #(.N(N_ENTRIES), .W(AW)) u_off_ctr (
        .clk(clk), .rst_n(rst_n), .load(off_load), .load_val('0),
        .step(off_step), .up(off_up), .value(offset)
    );

    scroll_pos_map #(.N(N_ENTRIES), .W(AW), .PW(PW)) u_pos_map (
        .offset(offset), .pos(pos_idx), .entry(pos_entry)
    );

    // mode flags and dot shift
    assign dot_code = cmd_arg[DOTW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_mode    <= 1'b1;
            shift_on_wr <= 1'b0;
            dot_shift   <= '0;
        end else if (accept_cmd) begin
            unique case (op)
                OP_ENTRY: begin
                    inc_mode    <= cmd_arg[1];
                    shift_on_wr <= cmd_arg[0];
                end
                OP_CLEAR:  inc_mode  <= 1'b1;
                OP_DSHIFT: dot_shift <= '0;
                OP_DOT:    dot_shift <= (dot_code > DOT_LIMIT) ? '0 : dot_code;
                default: ;
            endcase
        end
    end

    assert_clear_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_addr != LAST_SLOT) |=> (busy && mem_addr == $past(mem_addr) + 1'b1));
    assert_busy_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_cnt));
    assert_dshift_keeps_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_cmd && op == OP_DSHIFT) |=> ($stable(addr_cnt) && dot_shift == '0));
    assert_dot_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dot_shift <= DOT_LIMIT);
    assert_home_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_cmd && op == OP_HOME) |=> (addr_cnt == '0 && !mem_we));
endmodule

// File: tb/scroll_addr_ctrl_bench.sv
module scroll_addr_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd7;
    logic [7:0] cmd_arg = 8'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [3:0] pos_idx = 4'd0;
    logic [3:0] pos_entry, addr_cnt, mem_addr;
    logic [2:0] dot_shift;
    logic       busy, mem_we;
    logic [7:0] mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    int m_addr = 0;
    int m_off  = 0;
    int m_inc  = 1;
    int m_s    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    scroll_addr_ctrl u_scroll_addr_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .wr_valid(wr_valid), .wr_data(wr_data),
        .pos_idx(pos_idx), .pos_entry(pos_entry), .dot_shift(dot_shift),
        .addr_cnt(addr_cnt), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int wrap14(input int v);
        return ((v % 14) + 14) % 14;
    endfunction

    task automatic check_map(input string req);
        for (int p = 0; p < 12; p++) begin
            pos_idx = 4'(p);
            #1;
            chk(req, int'(pos_entry), wrap14(m_off + p));
        end
    endtask

    task automatic do_cmd(input int op, input int arg);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'(op);
        cmd_arg   = 8'(arg);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd7;
    endtask

    task automatic do_write(input int d, input string req);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = 8'(d);
        #1;
        chk({req, " mem_we"}, int'(mem_we), 1);
        chk({req, " mem_addr"}, int'(mem_addr), m_addr);
        chk({req, " mem_wdata"}, int'(mem_wdata), d);
        @(negedge clk);
        wr_valid = 1'b0;
        if (m_s != 0) m_off = wrap14(m_off + (m_inc != 0 ? 1 : -1));
        m_addr = wrap14(m_addr + (m_inc != 0 ? 1 : -1));
        chk({req, " addr after write"}, int'(addr_cnt), m_addr);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 reset addr", int'(addr_cnt), 0);
        chk("R13 reset busy", int'(busy), 0);
        chk("R13 reset dot", int'(dot_shift), 0);
        chk("R13 reset mem_we", int'(mem_we), 0);
        check_map("R13 reset offset");

        // R1 R5: sweep all offsets left, then wrap right
        for (int i = 0; i < 14; i++) begin
            do_cmd(3, 0);
            m_off = wrap14(m_off + 1);
            chk("R5 dshift keeps addr", int'(addr_cnt), m_addr);
            check_map("R1 left sweep");
        end
        for (int i = 0; i < 3; i++) begin
            do_cmd(3, 1);
            m_off = wrap14(m_off - 1);
            check_map("R1 right sweep wrap");
        end

        // R6 dot codes, then R5 reset of dot
        for (int v = 0; v < 8; v++) begin
            do_cmd(5, v);
            chk("R6 dot code", int'(dot_shift), (v > 5) ? 0 : v);
        end
        do_cmd(5, 4);
        do_cmd(3, 0);
        m_off = wrap14(m_off + 1);
        chk("R5 dshift clears dot", int'(dot_shift), 0);

        // R10 set address incl. wrap of 14/15
        for (int a = 0; a < 16; a++) begin
            do_cmd(6, a);
            m_addr = (a >= 14) ? a - 14 : a;
            chk("R10 set address", int'(addr_cnt), m_addr);
        end

        // R3 R2 increment writes through wrap
        do_cmd(6, 12);
        m_addr = 12;
        do_write(8'h41, "R3 inc 12");
        do_write(8'h42, "R2 inc 13->0");
        do_write(8'h43, "R3 inc 0");

        // R13 entry decrement, R2 wrap down
        do_cmd(2, 0);
        m_inc = 0; m_s = 0;
        do_write(8'h44, "R2 dec 1");
        do_write(8'h45, "R2 dec 0->13");
        check_map("R4 no shift when S=0");

        // R4 shift on write, both directions
        do_cmd(2, 3);
        m_inc = 1; m_s = 1;
        do_cmd(5, 3);
        do_write(8'h46, "R4 left shift write");
        check_map("R4 offset after left write");
        chk("R4 dot kept", int'(dot_shift), 3);
        do_cmd(2, 1);
        m_inc = 0;
        do_write(8'h47, "R4 right shift write");
        check_map("R4 offset after right write");

        // R9 address shift both directions with wrap
        do_cmd(6, 13);
        m_addr = 13;
        do_cmd(4, 1);
        m_addr = 0;
        chk("R9 ashift right wrap", int'(addr_cnt), m_addr);
        do_cmd(4, 0);
        m_addr = 13;
        chk("R9 ashift left wrap", int'(addr_cnt), m_addr);
        chk("R9 no write", int'(mem_we), 0);

        // R8 return home
        do_cmd(1, 0);
        m_addr = 0; m_off = 0;
        chk("R8 home addr", int'(addr_cnt), 0);
        check_map("R8 home offset");

        // R7 clear with R11 intrusion; S=1, I/D=0 before
        do_cmd(3, 0); do_cmd(3, 0);
        m_off = 2;
        do_cmd(6, 5);
        do_cmd(0, 0);
        m_addr = 0; m_inc = 1;
        for (int k = 0; k < 14; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 3) begin
                cmd_valid = 1'b1; cmd_op = 3'd6; cmd_arg = 8'd7;
                wr_valid = 1'b1; wr_data = 8'h5A;
            end
            if (k == 4) begin
                cmd_valid = 1'b0; cmd_op = 3'd7; wr_valid = 1'b0;
            end
            #1;
            chk("R7 busy", int'(busy), 1);
            chk("R7 clear we", int'(mem_we), 1);
            chk("R7 clear addr", int'(mem_addr), k);
            chk("R11 clear data", int'(mem_wdata), 32);
            chk("R11 addr held", int'(addr_cnt), 0);
        end
        @(negedge clk);
        chk("R7 busy released", int'(busy), 0);
        chk("R11 addr after clear", int'(addr_cnt), 0);
        chk("R7 no write after", int'(mem_we), 0);
        check_map("R7 offset kept");
        do_write(8'h48, "R7 inc forced S kept");
        check_map("R7 S kept shifts");

        // R12 command wins over write
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_arg = 8'd1;
        wr_valid = 1'b1; wr_data = 8'h55;
        #1;
        chk("R12 write dropped", int'(mem_we), 0);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd7; wr_valid = 1'b0;
        m_addr = wrap14(m_addr + 1);
        chk("R12 command done", int'(addr_cnt), m_addr);
        check_map("R12 no write shift");

        done = 1'b1;
        finish_run();
    end
endmodule